// File: doc/BRIEF.md
# Accumulator ALU with Store Shifter

This block is a 32-bit arithmetic and logic datapath built around an accumulator and a 32-bit buffer register. On every operation, the accumulator is the first ALU operand, and the result is written back into it. The second operand comes from one of three places: a product input from an external multiplier, the buffer, or a 32-bit value that an external scaling shifter has already prepared.

The operation set covers the following:
- load, add and subtract;
- bitwise AND, OR and XOR;
- a one-cycle right shift of 1 to 16 places;
- one left step of normalization per cycle;
- a fast save of the accumulator into the buffer;
- minimum and maximum compare-and-select between the accumulator and the buffer.

A separate combinational store port presents either half of the accumulator shifted left by 0 to 7 places. It never alters the register.

Top module: `acc_alu`

## Requirements
- R1: After reset, the accumulator, buffer, carry and normalize-done flag are all zero.
- R2: The operation code `op` selects the function:
  - 0 = no-op, 1 = load, 2 = add, 3 = subtract;
  - 4 = AND, 5 = OR, 6 = XOR;
  - 7 = right shift, 8 = normalize step, 9 = save;
  - 10 = minimum, 11 = maximum.
  
  `src_sel` picks the second operand: 0 = product input, 1 = buffer, 2 or 3 = pre-scaled input. Load, add and subtract take effect on the next clock edge. Add sets carry to the unsigned carry-out. Subtract sets carry to 1 when no borrow occurs (unsigned accumulator >= operand). Load leaves carry unchanged.
- R3: AND, OR and XOR combine the accumulator with the selected operand bitwise, and do not change carry.
- R4: With `st_half` = 1, `st_data` equals bits 31..16 of the accumulator shifted left by `st_shift`. Its top bits are dropped, and its vacated low bits take the upper bits of the low half.
- R5: With `st_half` = 0, `st_data` equals bits 15..0 shifted left by `st_shift`, with zeros filling from the right. Presenting a store does not change the accumulator.
- R6: The right shift moves the accumulator right by `rsh_amt`+1 places (1 to 16). The shift is arithmetic when `sxm` = 1 and logical when `sxm` = 0.
- R7: Save copies the accumulator into the buffer in one cycle and leaves the accumulator unchanged. Selecting the buffer as the operand of a load brings it back.
- R8: Minimum compares the two registers as signed values. If the buffer is less than the accumulator, both registers take the buffer value and carry becomes 1. Otherwise both take the accumulator value and carry becomes 0.
- R9: Maximum compares the two registers as signed values. If the buffer is greater than the accumulator, both registers take the buffer value and carry becomes 1. Otherwise both take the accumulator value and carry becomes 0.
- R10: A normalize step behaves as follows:
  - If the accumulator is zero, or bit 31 differs from bit 30, the accumulator is held and `norm_done` is set to 1.
  - Otherwise the accumulator shifts left by one and `norm_done` is cleared.
  - `norm_done` changes only on normalize steps.
- R11: A no-op leaves the accumulator, buffer and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| src_sel | input | 2 | Second-operand select |
| prod_in | input | 32 | Product register value |
| scaled_in | input | 32 | Pre-scaled operand |
| rsh_amt | input | 4 | Right-shift amount minus one |
| sxm | input | 1 | Sign-extension mode for right shift |
| st_half | input | 1 | Store half select (1 = high) |
| st_shift | input | 3 | Store left-shift amount |
| acc | output | 32 | Accumulator |
| accb | output | 32 | Accumulator buffer |
| carry | output | 1 | Carry flag |
| norm_done | output | 1 | Normalization complete flag |
| st_data | output | 16 | Shifted store word |

## Verification
The hardest states to reach are the compare outcomes with carry set. They need the buffer to hold a chosen value that is then bracketed on both sides by a new accumulator value. The stimulus loads a value, saves it, then loads values below and above it, so each minimum and maximum takes both the selected and the not-selected branch. Normalization is driven step by step from a value with nine redundant sign bits, until the done flag rises.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W   = 32,
  parameter int SW  = 3,
  parameter int RSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op,
  input  logic [1:0]      src_sel,
  input  logic [W-1:0]    prod_in,
  input  logic [W-1:0]    scaled_in,
  input  logic [RSW-1:0]  rsh_amt,
  input  logic            sxm,
  input  logic            st_half,
  input  logic [SW-1:0]   st_shift,
  output logic [W-1:0]    acc,
  output logic [W-1:0]    accb,
  output logic            carry,
  output logic            norm_done,
  output logic [W/2-1:0]  st_data
);
  localparam int HW = W / 2;
  localparam logic [3:0] OP_NOP = 4'd0, OP_LD = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_SHR = 4'd7,
                         OP_NORM = 4'd8, OP_SAVE = 4'd9, OP_MIN = 4'd10, OP_MAX = 4'd11;

  logic [W-1:0] opnd, rsh, st_full;
  logic [W:0]   sum, dif;
  logic [RSW:0] rsh_n;
  logic         b_lt_a, b_gt_a, norm_stop;

  assign opnd = (src_sel == 2'd0) ? prod_in : (src_sel == 2'd1) ? accb : scaled_in;
  assign sum  = {1'b0, acc} + {1'b0, opnd};
  assign dif  = {1'b0, acc} - {1'b0, opnd};
  assign rsh_n = {1'b0, rsh_amt} + 1'b1;
  assign rsh  = sxm ? W'($signed(acc) >>> rsh_n) : (acc >> rsh_n);
  assign b_lt_a = $signed(accb) < $signed(acc);
  assign b_gt_a = $signed(accb) > $signed(acc);
  assign norm_stop = (acc == '0) || (acc[W-1] != acc[W-2]);

  assign st_full = acc << st_shift;
  assign st_data = st_half ? st_full[W-1:HW] : st_full[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      accb <= '0;
      carry <= 1'b0;
      norm_done <= 1'b0;
    end else begin
      case (op)
        OP_LD:  acc <= opnd;
        OP_ADD: begin acc <= sum[W-1:0]; carry <= sum[W]; end
        OP_SUB: begin acc <= dif[W-1:0]; carry <= ~dif[W]; end
        OP_AND: acc <= acc & opnd;
        OP_OR:  acc <= acc | opnd;
        OP_XOR: acc <= acc ^ opnd;
        OP_SHR: acc <= rsh;
        OP_NORM: begin
          norm_done <= norm_stop;
          if (!norm_stop) acc <= acc << 1;
        end
        OP_SAVE: accb <= acc;
        OP_MIN: begin
          carry <= b_lt_a;
          if (b_lt_a) acc <= accb; else accb <= acc;
        end
        OP_MAX: begin
          carry <= b_gt_a;
          if (b_gt_a) acc <= accb; else accb <= acc;
        end
        default: ;
      endcase
    end
  end
endmodule

module acc_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         st_half,
  input logic [2:0]   st_shift,
  input logic [W-1:0] acc,
  input logic [W-1:0] accb,
  input logic         carry,
  input logic         norm_done,
  input logic [W/2-1:0] st_data
);
  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd0) |=> ($stable(acc) && $stable(accb) && $stable(carry))); // R11
  AST_SAVE_COPIES: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd9) |=> (accb == $past(acc) && acc == $past(acc))); // R7
  AST_MIN_AGREES: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd10) |=> (acc == accb && carry == ($signed($past(accb)) < $signed($past(acc))))); // R8
  AST_MAX_AGREES: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd11) |=> (acc == accb && carry == ($signed($past(accb)) > $signed($past(acc))))); // R9
  AST_NORM_STEP: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd8 && acc != '0 && acc[W-1] == acc[W-2]) |=> (acc == ($past(acc) << 1) && !norm_done)); // R10
  AST_LOW_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (!st_half && st_shift != 3'd0) |-> (st_data[0] == 1'b0)); // R5
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .st_half(st_half), .st_shift(st_shift),
  .acc(acc), .accb(accb), .carry(carry), .norm_done(norm_done), .st_data(st_data)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [1:0]  src_sel = 2'd2;
  logic [31:0] prod_in = '0, scaled_in = '0;
  logic [3:0]  rsh_amt = '0;
  logic        sxm = 1'b0, st_half = 1'b0;
  logic [2:0]  st_shift = '0;
  logic [31:0] acc, accb;
  logic        carry, norm_done;
  logic [15:0] st_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .src_sel(src_sel), .prod_in(prod_in),
    .scaled_in(scaled_in), .rsh_amt(rsh_amt), .sxm(sxm), .st_half(st_half),
    .st_shift(st_shift), .acc(acc), .accb(accb), .carry(carry),
    .norm_done(norm_done), .st_data(st_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [31:0] v);
    op = o; src_sel = s; scaled_in = v; prod_in = v;
    @(negedge clk);
    op = 4'd0;
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 0); chk("R1 accb", accb, 0);
    chk("R1 carry", {31'b0, carry}, 0); chk("R1 done", {31'b0, norm_done}, 0);
  endtask

  task automatic t_arith;
    run(4'd1, 2'd2, 32'h12345678); chk("R2 load", acc, 32'h12345678);
    run(4'd2, 2'd0, 32'hF0000000); chk("R2 add", acc, 32'h02345678);
    chk("R2 add carry", {31'b0, carry}, 1);
    run(4'd3, 2'd0, 32'h02345679); chk("R2 sub", acc, 32'hFFFFFFFF);
    chk("R2 sub borrow", {31'b0, carry}, 0);
    run(4'd3, 2'd1, 32'h0); chk("R2 sub buffer", acc, 32'hFFFFFFFF);
    chk("R2 sub noborrow", {31'b0, carry}, 1);
  endtask

  task automatic t_logic;
    run(4'd1, 2'd2, 32'hF0F0F0F0);
    run(4'd4, 2'd2, 32'hFF00FF00); chk("R3 and", acc, 32'hF000F000);
    run(4'd5, 2'd3, 32'h0F000000); chk("R3 or", acc, 32'hFF00F000);
    run(4'd6, 2'd0, 32'hFFFFFFFF); chk("R3 xor", acc, 32'h00FF0FFF);
    chk("R3 carry kept", {31'b0, carry}, 1);
  endtask

  task automatic t_store;
    run(4'd1, 2'd2, 32'h81234567);
    st_half = 1'b1; st_shift = 3'd0; #1 chk("R4 high sh0", {16'b0, st_data}, 32'h8123);
    st_shift = 3'd4; #1 chk("R4 high sh4", {16'b0, st_data}, 32'h1234);
    st_shift = 3'd7; #1 chk("R4 high sh7", {16'b0, st_data}, 32'h91A2);
    st_half = 1'b0; st_shift = 3'd4; #1 chk("R5 low sh4", {16'b0, st_data}, 32'h5670);
    st_shift = 3'd7; #1 chk("R5 low sh7", {16'b0, st_data}, 32'hB380);
    @(negedge clk);
    chk("R5 acc unchanged", acc, 32'h81234567);
    st_shift = 3'd0;
  endtask

  task automatic t_shift;
    run(4'd1, 2'd2, 32'h80000000);
    sxm = 1'b1; rsh_amt = 4'd15; run(4'd7, 2'd2, 0); chk("R6 arith 16", acc, 32'hFFFF8000);
    run(4'd1, 2'd2, 32'h80000000);
    sxm = 1'b0; rsh_amt = 4'd0; run(4'd7, 2'd2, 0); chk("R6 logic 1", acc, 32'h40000000);
    run(4'd1, 2'd2, 32'h80000000);
    rsh_amt = 4'd15; run(4'd7, 2'd2, 0); chk("R6 logic 16", acc, 32'h00008000);
  endtask

  task automatic t_save;
    run(4'd1, 2'd2, 32'h11112222);
    run(4'd9, 2'd2, 0); chk("R7 buffer", accb, 32'h11112222); chk("R7 acc kept", acc, 32'h11112222);
    run(4'd1, 2'd2, 32'd5);
    run(4'd1, 2'd1, 0); chk("R7 restore", acc, 32'h11112222);
  endtask

  task automatic t_minmax;
    run(4'd1, 2'd2, 32'd16); run(4'd9, 2'd2, 0);
    run(4'd1, 2'd2, -32'sd16);
    run(4'd10, 2'd2, 0); chk("R8 min keep acc", accb, 32'hFFFFFFF0); chk("R8 carry0", {31'b0, carry}, 0);
    run(4'd1, 2'd2, 32'd5);
    run(4'd10, 2'd2, 0); chk("R8 min buffer", acc, 32'hFFFFFFF0); chk("R8 carry1", {31'b0, carry}, 1);
    run(4'd1, 2'd2, 32'd100);
    run(4'd11, 2'd2, 0); chk("R9 max keep acc", accb, 32'd100); chk("R9 carry0", {31'b0, carry}, 0);
    run(4'd1, 2'd2, -32'sd200);
    run(4'd11, 2'd2, 0); chk("R9 max buffer", acc, 32'd100); chk("R9 carry1", {31'b0, carry}, 1);
  endtask

  task automatic t_norm;
    run(4'd1, 2'd2, 32'h00300000);
    for (int i = 0; i < 9; i++) run(4'd8, 2'd2, 0);
    chk("R10 after 9", acc, 32'h60000000); chk("R10 not done", {31'b0, norm_done}, 0);
    run(4'd8, 2'd2, 0);
    chk("R10 hold", acc, 32'h60000000); chk("R10 done", {31'b0, norm_done}, 1);
    run(4'd1, 2'd2, 32'h00000001);
    chk("R10 done kept", {31'b0, norm_done}, 1);
    run(4'd8, 2'd2, 0); chk("R10 cleared", {31'b0, norm_done}, 0);
    run(4'd1, 2'd2, 0); run(4'd8, 2'd2, 0);
    chk("R10 zero done", {31'b0, norm_done}, 1); chk("R10 zero acc", acc, 0);
  endtask

  task automatic t_nop;
    run(4'd1, 2'd2, 32'hCAFE0001);
    run(4'd0, 2'd2, 32'h0); run(4'd0, 2'd0, 32'h12);
    chk("R11 acc", acc, 32'hCAFE0001); chk("R11 accb", accb, 32'd100);
  endtask

  initial begin
    fork
      begin
        #50000;
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith(); t_logic(); t_store(); t_shift();
        t_save(); t_minmax(); t_norm(); t_nop();
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule